// File: doc/BRIEF.md
# I2C Quasi-Bidirectional Port Expander

This block is an I2C target that controls an 8-bit quasi-bidirectional I/O port. A controller addresses it and then either writes bytes to the port's output latches or reads back the levels present on the pins. Each pin has only a pull-low driver and a brief strong pull-up. Writing a 0 to a pin drives it low. Writing a 1 releases it, so the pin rests on a weak external pull-up and can be used as an input. On every 0-to-1 latch change the pin gets a short strong pull-up burst so that it rises quickly.

SCL and SDA arrive as raw inputs. They are resynchronised to the system clock and oversampled, so a system clock of about 16 times the bus bit rate is enough for Standard, Fast and 1 MHz operation. SDA is driven only as an open-drain pull-low enable. Three 2-bit address straps give 64 target addresses.

Three sources put every pin into the released (input) state:
- the power-on reset;
- an active-low hardware reset input;
- a general-call software reset command.

Top module: `qbx_expander`

## Requirements
- R1: While reset is asserted and immediately after it is released, `pin_low_o`, `pin_boost_o` and `sda_pull_o` are all zero. Every output latch holds 1.
- R2: The target acknowledges the first byte after a START only when bits [7:1] equal its address. Other addresses get no acknowledge and leave the latches unchanged. The address is {s2[1], ~s1[1], s0[1], 0, s2[0], s1[0], s0[0]}, where sN is strap N coded as 00 tied low, 01 tied high, 10 tied to SCL, 11 tied to SDA. Plain straps therefore give 0100 followed by the three strap levels.
- R3: Each data byte written to the target is acknowledged and loaded into the latches at its acknowledge. After that, `pin_low_o` equals the bitwise inverse of the byte (bit i drives pin i).
- R4: Several data bytes in one write transfer update the latches in order, one byte per acknowledge.
- R5: A read returns the pin levels, MSB first, as sampled at the acknowledge of the address byte for the first byte and at each controller ACK for every later byte. A pin that the target drives low reads as 0.
- R6: A controller NACK ends a read. SDA is released and the next transfer is decoded normally.
- R7: When a write changes a latch bit from 0 to 1, `pin_boost_o` for that pin is high for exactly 4 system clock cycles. Pins that do not rise get no boost, and a boosted pin is never driven low at the same time.
- R8: Driving `hw_rst_n` low returns all latches to 1 (all pins released) and clears any boost.
- R9: General-call address 0x00 (write) followed by data 0x06 is acknowledged on both bytes. It resets all latches to 1, and the reset takes effect only at the following STOP.
- R10: A general-call data byte other than 0x06 is not acknowledged and has no effect on the latches.
- R11: The address byte's LSB selects the direction: 1 for read, 0 for write. A read transfer leaves the latches unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| hw_rst_n | input | 1 | Hardware reset pin, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | Pulls SDA low when 1 |
| strap2_i | input | 2 | Address strap 2 connection code |
| strap1_i | input | 2 | Address strap 1 connection code |
| strap0_i | input | 2 | Address strap 0 connection code |
| pin_i | input | 8 | Sensed pin levels |
| pin_low_o | output | 8 | Pull-low enable per pin |
| pin_boost_o | output | 8 | Strong pull-up enable per pin |

## Verification
The bench targets when reads are sampled. It changes the pins after the address acknowledge and expects the first byte to hold the old levels and the second the new ones. A design that sampled at each byte's first bit, or only once per transfer, returns the wrong byte. The boost window is counted cycle by cycle and its mask is compared with the rising bits; an off-by-one counter or a boost on every written 1 shows up there. The software reset is checked both before and after the STOP, which exposes a design that acts at the data acknowledge. A non-matching general-call byte and a wrong address are checked for a missing acknowledge and an unchanged port.

// File: rtl/qbx_pkg.sv
package qbx_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK
  } bus_st_e;

  localparam logic [7:0] GC_ADDR_BYTE  = 8'h00;
  localparam logic [7:0] GC_RESET_CODE = 8'h06;

  // strap code: 00 low, 01 high, 10 tied to SCL, 11 tied to SDA
  function automatic logic [6:0] strap_addr(input logic [1:0] s2,
                                            input logic [1:0] s1,
                                            input logic [1:0] s0);
    return {s2[1], ~s1[1], s0[1], 1'b0, s2[0], s1[0], s0[0]};
  endfunction
endpackage

// File: rtl/qbx_sync.sv
module qbx_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= {W{RST_VAL}};
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= {W{RST_VAL}};
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qbx_bus_target.sv
module qbx_bus_target
  import qbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [6:0]        my_addr,
  input  logic [BYTE_W-1:0] cap_data,
  output logic              sda_pull,
  output logic              wr_pulse,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_pulse,
  output logic              sw_rst
);
  logic scl_d, sda_d;
  logic rise, fall, start, stop;

  bus_st_e           st, st_n;
  logic [3:0]        cnt, cnt_n;
  logic [BYTE_W-1:0] sh, sh_n;
  logic              pull_n, gc, gc_n, rw, rw_n, pend, pend_n;
  logic              wr_n, rd_n, swr_n;

  assign rise  = scl_s & ~scl_d;
  assign fall  = ~scl_s & scl_d;
  assign start = scl_s & scl_d & sda_d & ~sda_s;
  assign stop  = scl_s & scl_d & ~sda_d & sda_s;

  always_comb begin
    st_n = st; cnt_n = cnt; sh_n = sh; pull_n = sda_pull;
    gc_n = gc; rw_n = rw; pend_n = pend;
    wr_n = 1'b0; rd_n = 1'b0; swr_n = 1'b0;
    if (stop) begin
      st_n = ST_IDLE; pull_n = 1'b0; swr_n = pend; pend_n = 1'b0;
    end else if (start) begin
      st_n = ST_ADDR; cnt_n = '0; pull_n = 1'b0; pend_n = 1'b0;
    end else begin
      unique case (st)
        ST_ADDR, ST_WDATA: begin
          if (rise) begin
            sh_n  = {sh[BYTE_W-2:0], sda_s};
            cnt_n = cnt + 4'd1;
          end else if (fall && cnt == 4'd8) begin
            if (st == ST_ADDR) begin
              if (sh == GC_ADDR_BYTE) begin
                pull_n = 1'b1; gc_n = 1'b1; rw_n = 1'b0; st_n = ST_AACK;
              end else if (sh[7:1] == my_addr) begin
                pull_n = 1'b1; gc_n = 1'b0; rw_n = sh[0]; st_n = ST_AACK;
                rd_n = sh[0];
              end else begin
                st_n = ST_IDLE;
              end
            end else if (gc) begin
              if (sh == GC_RESET_CODE) begin
                pull_n = 1'b1; pend_n = 1'b1; st_n = ST_WACK;
              end else begin
                st_n = ST_IDLE;
              end
            end else begin
              pull_n = 1'b1; wr_n = 1'b1; st_n = ST_WACK;
            end
          end
        end
        ST_AACK, ST_RACK: begin
          if (fall) begin
            if (st == ST_AACK && !rw) begin
              st_n = ST_WDATA; pull_n = 1'b0; cnt_n = '0;
            end else begin
              st_n = ST_RDATA; pull_n = ~cap_data[BYTE_W-1];
              sh_n = {cap_data[BYTE_W-2:0], 1'b0}; cnt_n = 4'd1;
            end
          end else if (rise && st == ST_RACK) begin
            if (sda_s) st_n = ST_IDLE;
            else       rd_n = 1'b1;
          end
        end
        ST_WACK: begin
          if (fall) begin
            pull_n = 1'b0; cnt_n = '0;
            st_n = gc ? ST_IDLE : ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (fall) begin
            if (cnt == 4'd8) begin
              pull_n = 1'b0; st_n = ST_RACK;
            end else begin
              pull_n = ~sh[BYTE_W-1];
              sh_n = {sh[BYTE_W-2:0], 1'b0};
              cnt_n = cnt + 4'd1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1; sda_d <= 1'b1;
      st <= ST_IDLE; cnt <= '0; sh <= '0; sda_pull <= 1'b0;
      gc <= 1'b0; rw <= 1'b0; pend <= 1'b0;
      wr_pulse <= 1'b0; rd_pulse <= 1'b0; sw_rst <= 1'b0;
    end else if (clr) begin
      scl_d <= scl_s; sda_d <= sda_s;
      st <= ST_IDLE; cnt <= '0; sh <= '0; sda_pull <= 1'b0;
      gc <= 1'b0; rw <= 1'b0; pend <= 1'b0;
      wr_pulse <= 1'b0; rd_pulse <= 1'b0; sw_rst <= 1'b0;
    end else begin
      scl_d <= scl_s; sda_d <= sda_s;
      st <= st_n; cnt <= cnt_n; sh <= sh_n; sda_pull <= pull_n;
      gc <= gc_n; rw <= rw_n; pend <= pend_n;
      wr_pulse <= wr_n; rd_pulse <= rd_n; sw_rst <= swr_n;
    end
  end

  assign wr_data = sh;
endmodule

// File: rtl/qbx_port.sv
module qbx_port #(
  parameter int W            = 8,
  parameter int BOOST_CYCLES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr_pulse,
  input  logic [W-1:0] wr_data,
  input  logic         rd_pulse,
  input  logic [W-1:0] pin_s,
  output logic [W-1:0] cap_o,
  output logic [W-1:0] pin_low_o,
  output logic [W-1:0] pin_boost_o
);
  localparam int CW = $clog2(BOOST_CYCLES + 1);

  logic [W-1:0]  latch, latch_n, cap_n, bmask, bmask_n;
  logic [CW-1:0] bcnt, bcnt_n;
  logic          bon;

  always_comb begin
    latch_n = latch; cap_n = cap_o; bmask_n = bmask; bcnt_n = bcnt;
    if (clr) begin
      latch_n = '1; bmask_n = '0; bcnt_n = '0;
    end else begin
      if (bcnt != '0) bcnt_n = bcnt - 1'b1;
      if (wr_pulse) begin
        latch_n = wr_data;
        bmask_n = wr_data & ~latch;
        bcnt_n  = (|(wr_data & ~latch)) ? CW'(BOOST_CYCLES) : '0;
      end
      if (rd_pulse) cap_n = pin_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch <= '1; cap_o <= '0; bmask <= '0; bcnt <= '0;
    end else begin
      latch <= latch_n; cap_o <= cap_n; bmask <= bmask_n; bcnt <= bcnt_n;
    end
  end

  assign bon = (bcnt != '0);

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pin_low_o[i]   = ~latch[i];
    assign pin_boost_o[i] = bmask[i] & bon;
  end
endmodule

// File: rtl/qbx_expander.sv
module qbx_expander
  import qbx_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int BOOST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [1:0] strap2_i,
  input  logic [1:0] strap1_i,
  input  logic [1:0] strap0_i,
  input  logic [7:0] pin_i,
  output logic [7:0] pin_low_o,
  output logic [7:0] pin_boost_o
);
  logic              rst_q, hw_q, clr;
  logic              scl_s, sda_s;
  logic [BYTE_W-1:0] pin_s, cap, wr_data;
  logic              wr_pulse, rd_pulse, sw_rst;
  logic [6:0]        my_addr;

  qbx_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_q));

  qbx_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_hw_sync (
    .clk(clk), .rst_n(rst_q), .d(hw_rst_n), .q(hw_q));

  qbx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_bus_sync (
    .clk(clk), .rst_n(rst_q), .d({scl_i, sda_i}), .q({scl_s, sda_s}));

  qbx_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(rst_q), .d(pin_i), .q(pin_s));

  assign my_addr = strap_addr(strap2_i, strap1_i, strap0_i);
  assign clr     = ~hw_q | sw_rst;

  qbx_bus_target u_bus (
    .clk(clk), .rst_n(rst_q), .clr(~hw_q), .scl_s(scl_s), .sda_s(sda_s),
    .my_addr(my_addr), .cap_data(cap), .sda_pull(sda_pull_o),
    .wr_pulse(wr_pulse), .wr_data(wr_data), .rd_pulse(rd_pulse),
    .sw_rst(sw_rst));

  qbx_port #(.W(BYTE_W), .BOOST_CYCLES(BOOST_CYCLES)) u_port (
    .clk(clk), .rst_n(rst_q), .clr(clr), .wr_pulse(wr_pulse),
    .wr_data(wr_data), .rd_pulse(rd_pulse), .pin_s(pin_s), .cap_o(cap),
    .pin_low_o(pin_low_o), .pin_boost_o(pin_boost_o));
endmodule

// File: rtl/qbx_expander_chk.sv
module qbx_expander_chk #(
  parameter int BOOST_CYCLES = 4
) (
  input logic       clk,
  input logic       rst_q,
  input logic       scl_s,
  input logic       sda_pull_o,
  input logic [7:0] pin_low_o,
  input logic [7:0] pin_boost_o,
  input logic       wr_pulse,
  input logic       clr
);
  logic [15:0] run;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)                 run <= '0;
    else if (pin_boost_o == '0) run <= '0;
    else if (run != 16'hFFFF)   run <= run + 16'd1;
  end

  // R3: latches move only on a write pulse or a clear
  a_r3_latch_on_write: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(pin_low_o) |-> ($past(wr_pulse) || $past(clr)));

  // R7: boost window never longer than its configured length
  a_r7_boost_window: assert property (@(posedge clk) disable iff (!rst_q)
    run <= 16'(BOOST_CYCLES));

  // R7: a boosted pin is not also pulled low
  a_r7_boost_released: assert property (@(posedge clk) disable iff (!rst_q)
    (pin_boost_o & pin_low_o) == 8'h00);

  // R8, R9: a clear leaves all pins released with no boost
  a_r8_clear_releases: assert property (@(posedge clk) disable iff (!rst_q)
    $past(clr) |-> (pin_low_o == 8'h00 && pin_boost_o == 8'h00));

  // R6: SDA is only newly pulled while the bus clock is low
  a_r6_pull_on_low_scl: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(sda_pull_o) |-> !$past(scl_s));
endmodule

bind qbx_expander qbx_expander_chk #(.BOOST_CYCLES(BOOST_CYCLES)) u_chk (
  .clk(clk), .rst_q(rst_q), .scl_s(scl_s), .sda_pull_o(sda_pull_o),
  .pin_low_o(pin_low_o), .pin_boost_o(pin_boost_o), .wr_pulse(wr_pulse),
  .clr(clr));

// File: tb/tb_qbx_expander.sv
module tb_qbx_expander;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n, hw_rst_n, scl_m, sda_m;
  logic [1:0] s2, s1, s0;
  logic [7:0] pin_ext;
  logic sda_pull_o;
  logic [7:0] pin_low_o, pin_boost_o;
  wire  sda_line = sda_m & ~sda_pull_o;
  wire [7:0] pin_lvl = pin_ext & ~pin_low_o;

  int checks = 0, fails = 0;
  int bcyc = 0;
  logic [7:0] bmask = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  qbx_expander dut (
    .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .scl_i(scl_m),
    .sda_i(sda_line), .sda_pull_o(sda_pull_o), .strap2_i(s2),
    .strap1_i(s1), .strap0_i(s0), .pin_i(pin_lvl),
    .pin_low_o(pin_low_o), .pin_boost_o(pin_boost_o));

  always @(negedge clk) if (pin_boost_o != 8'h00) begin
    bcyc  = bcyc + 1;
    bmask = bmask | pin_boost_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic bstart;
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic bstop;
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(Q); scl_m = 1'b1; wt(2*Q); scl_m = 1'b0; wt(Q);
    end
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
    ack = ~sda_line; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl_m = 1'b1; wt(Q); b[i] = sda_line; wt(Q); scl_m = 1'b0;
    end
    wt(Q); sda_m = ~give_ack; wt(Q); scl_m = 1'b1; wt(2*Q); scl_m = 1'b0;
    wt(Q); sda_m = 1'b1;
  endtask

  task automatic wr_port(input logic [6:0] a, input logic [7:0] d);
    logic k;
    bstart; wbyte({a, 1'b0}, k); wbyte(d, k); bstop; wt(4);
  endtask

  task automatic t_reset;
    chk("R1 pin_low", pin_low_o, 8'h00);
    chk("R1 boost", pin_boost_o, 8'h00);
    chk("R1 sda_pull", sda_pull_o, 0);
  endtask

  task automatic t_write;
    logic k;
    bcyc = 0; bmask = 8'h00;
    bstart; wbyte(8'h44, k); chk("R2 addr ack", k, 1);
    wbyte(8'hA5, k); chk("R3 data ack", k, 1);
    wt(4); chk("R3 latch", pin_low_o, 8'h5A);
    bstop; wt(4);
    chk("R7 no rise no boost", bcyc, 0);
  endtask

  task automatic t_boost;
    bcyc = 0; bmask = 8'h00;
    wr_port(7'h22, 8'hFF);
    chk("R7 boost cycles", bcyc, 4);
    chk("R7 boost mask", bmask, 8'h5A);
    chk("R3 all released", pin_low_o, 8'h00);
  endtask

  task automatic t_multi;
    logic k;
    bstart; wbyte(8'h44, k);
    wbyte(8'h0F, k); wt(4); chk("R4 byte1", pin_low_o, 8'hF0);
    wbyte(8'hF0, k); wt(4); chk("R4 byte2", pin_low_o, 8'h0F);
    wbyte(8'h3C, k); wt(4); chk("R4 byte3", pin_low_o, 8'hC3);
    bstop; wt(4);
  endtask

  task automatic t_wrong;
    logic k;
    bstart; wbyte(8'h46, k); chk("R2 wrong addr nack", k, 0);
    wbyte(8'h00, k); bstop; wt(4);
    chk("R2 wrong addr no change", pin_low_o, 8'hC3);
  endtask

  task automatic t_read;
    logic k; logic [7:0] d;
    wr_port(7'h22, 8'hFF);
    pin_ext = 8'hC3;
    bstart; wbyte(8'h45, k); chk("R11 read addr ack", k, 1);
    pin_ext = 8'h99;
    rbyte(1'b1, d); chk("R5 first byte at addr ack", d, 8'hC3);
    rbyte(1'b0, d); chk("R5 second byte at master ack", d, 8'h99);
    wt(2); chk("R6 released after nack", sda_pull_o, 0);
    bstop; wt(4);
    chk("R11 read leaves latch", pin_low_o, 8'h00);
    wr_port(7'h22, 8'hF0);
    chk("R6 write after read", pin_low_o, 8'h0F);
    pin_ext = 8'hFF;
    bstart; wbyte(8'h45, k); rbyte(1'b0, d); bstop; wt(4);
    chk("R5 driven low reads 0", d, 8'hF0);
  endtask

  task automatic t_straps;
    logic k;
    s2 = 2'b11; s1 = 2'b10; s0 = 2'b01; wt(2);
    bstart; wbyte(8'h44, k); bstop; wt(4);
    chk("R2 old addr nack", k, 0);
    bstart; wbyte(8'h8A, k); chk("R2 strap addr ack", k, 1);
    wbyte(8'h11, k); bstop; wt(4);
    chk("R2 strap addr write", pin_low_o, 8'hEE);
  endtask

  task automatic t_hwrst;
    hw_rst_n = 1'b0; wt(6);
    chk("R8 hw reset releases", pin_low_o, 8'h00);
    chk("R8 hw reset boost", pin_boost_o, 8'h00);
    hw_rst_n = 1'b1; wt(6);
  endtask

  task automatic t_gc;
    logic k;
    wr_port(7'h45, 8'h00);
    chk("R9 pre latch", pin_low_o, 8'hFF);
    bstart; wbyte(8'h00, k); chk("R9 gc addr ack", k, 1);
    wbyte(8'h07, k); chk("R10 other code nack", k, 0);
    bstop; wt(8);
    chk("R10 no effect", pin_low_o, 8'hFF);
    bstart; wbyte(8'h00, k); wbyte(8'h06, k); chk("R9 code ack", k, 1);
    wt(8); chk("R9 held until stop", pin_low_o, 8'hFF);
    bstop; wt(8);
    chk("R9 reset at stop", pin_low_o, 8'h00);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run;
  end

  initial begin
    rst_n = 1'b0; hw_rst_n = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
    s2 = 2'b00; s1 = 2'b01; s0 = 2'b00; pin_ext = 8'hFF;
    wt(3);
    t_reset;
    rst_n = 1'b1; wt(6);
    t_reset;
    t_write;
    t_boost;
    t_multi;
    t_wrong;
    t_read;
    t_straps;
    t_hwrst;
    t_gc;
    finish_run;
  end
endmodule